// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

The block is one programmable sum-of-products cell array. A 36-bit input bus is widened into a 72-signal literal field, holding each input in both true and complemented form. An AND array forms 83 product terms from that field. Eighty of these are general terms. A routing stage gives them to 16 macrocell OR gates. Routing is limited to the group of four neighbouring macrocells that owns the term, and one term may feed several OR gates in its group. The other three terms have fixed jobs: an asynchronous preset, an asynchronous clear and a clock shared by the whole block. Each macrocell output comes either straight from its OR gate or from a flip-flop. The flip-flop is clocked by the system clock or by the shared clock term.

The whole configuration is a single bit stream. It is shifted in while the load enable is high. When the enable falls, the image is checked. An image that gives any macrocell more general terms than the limit is refused: a sticky error flag is raised and the earlier image stays active. Outputs are held low until the first image is accepted, and they stay low during any later load. The path from input to output has the same depth for every routing choice, because routing is only a per-term mask in front of a fixed OR tree.

Top module: `pt_logic_block`

## Requirements
- R1: Literal field bit j is input j for j < N_IN and the complement of input j-N_IN above that. Term t asserts exactly when every literal selected in its select word is high. The select word for term t is configuration bits [t*2*N_IN +: 2*N_IN]. Terms 0..N_GEN-1 are general, term N_GEN is preset, N_GEN+1 is clear and N_GEN+2 is the shared clock.
- R2: A term with an empty select word evaluates to 0, whatever the inputs.
- R3: A combinational macrocell outputs the OR of the general terms routed to it, in the same cycle as the input change.
- R4: General term g belongs to group g/GEN_PER_GRP. Routing bit AND_W + g*GRP + k sends it to macrocell (g/GEN_PER_GRP)*GRP + k. Several bits of one term may be set, so a single term feeds several macrocells.
- R5: A macrocell may receive any number of general terms up to MAX_PT (16 by default), including exactly MAX_PT. A macrocell with no terms outputs 0.
- R6: An image that gives some macrocell more than MAX_PT terms raises cfg_err_o. The previous image stays in effect. The flag stays high until rst_ni, and later valid images still commit.
- R7: mc_o is all-zero from reset until the first accepted image, and in every cycle while cfg_en_i is high.
- R8: Mode bit AND_W+MSK_W+2*m set makes macrocell m registered. With clock-select bit AND_W+MSK_W+2*m+1 clear, it loads its OR value on the rising edge of clk_i.
- R9: With the clock-select bit set, a registered macrocell loads only on a rising edge of the shared clock term and ignores clk_i.
- R10: The preset term sets every macrocell flip-flop and the clear term clears it, both without waiting for a clock. When both are high, clear wins.
- R11: Configuration bits enter on cfg_d_i, one per clk_i edge while cfg_en_i is high, bit 0 first. The image is checked and committed on the first edge at which cfg_en_i is seen low after a load, and cfg_done_o then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_d_i | input | 1 | Serial configuration data |
| in_i | input | 36 | Logic inputs |
| mc_o | output | 16 | Macrocell outputs |
| cfg_done_o | output | 1 | An image has been accepted |
| cfg_err_o | output | 1 | Sticky over-limit error |

## Verification
The hardest case to reach is the refusal of an over-limit image. It has to be told apart from a successful load, and the only evidence available at the ports is that the old behaviour stays in place. The bench runs a small instance with a limit of three terms. It first commits a valid image and sweeps every input value. It then loads an image that puts four terms on one macrocell, and repeats the full sweep against the old image. Finally it loads images at exactly the limit, with registered, term-clocked and preset/clear modes, and checks each one one edge at a time.

// File: rtl/pt_cfg_pkg.sv
package pt_cfg_pkg;
  // per-macrocell mode, bit0 = registered, bit1 = use product-term clock
  typedef struct packed {
    logic use_ptclk;
    logic registered;
  } mc_mode_t;

  localparam int MODE_W = 2;
  localparam int N_SPECIAL = 3;
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
  parameter int CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_d_i,
  input  logic             shadow_ok_i,
  output logic [CFG_W-1:0] shadow_o,
  output logic [CFG_W-1:0] act_o,
  output logic             en_q_o,
  output logic             done_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      act_o    <= '0;
      en_q_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      en_q_o <= cfg_en_i;
      if (cfg_en_i) shadow_o <= {cfg_d_i, shadow_o[CFG_W-1:1]};
      if (en_q_o && !cfg_en_i) begin
        if (shadow_ok_i) begin
          act_o  <= shadow_o;
          done_o <= 1'b1;
        end else begin
          err_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pt_cfg_check.sv
module pt_cfg_check #(
  parameter int N_MC        = 16,
  parameter int GRP         = 4,
  parameter int GEN_PER_GRP = 20,
  parameter int MAX_PT      = 16
) (
  input  logic [N_MC/GRP*GEN_PER_GRP*GRP-1:0] msk_i,
  output logic                                ok_o
);
  localparam int CNT_W = $clog2(GEN_PER_GRP + 1);

  logic [N_MC-1:0] over;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int G = m / GRP;
    localparam int K = m % GRP;
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int i = 0; i < GEN_PER_GRP; i++)
        cnt = cnt + {{(CNT_W-1){1'b0}}, msk_i[(G*GEN_PER_GRP + i)*GRP + K]};
    end
    assign over[m] = int'(cnt) > MAX_PT;
  end

  assign ok_o = ~|over;
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
  parameter int N_IN = 36,
  parameter int N_PT = 83
) (
  input  logic [N_IN-1:0]        in_i,
  input  logic [N_PT*2*N_IN-1:0] sel_i,
  output logic [N_PT-1:0]        pt_o
);
  localparam int FW = 2 * N_IN;

  logic [FW-1:0] field;
  assign field = {~in_i, in_i};

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [FW-1:0] sel;
    assign sel     = sel_i[t*FW +: FW];
    // empty select word yields 0, not 1
    assign pt_o[t] = (|sel) && ((field & sel) == sel);
  end
endmodule

// File: rtl/pt_allocator.sv
module pt_allocator #(
  parameter int N_MC        = 16,
  parameter int GRP         = 4,
  parameter int GEN_PER_GRP = 20
) (
  input  logic [N_MC/GRP*GEN_PER_GRP-1:0]     pt_i,
  input  logic [N_MC/GRP*GEN_PER_GRP*GRP-1:0] msk_i,
  output logic [N_MC-1:0]                     sum_o
);
  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int G = m / GRP;
    localparam int K = m % GRP;
    logic [GEN_PER_GRP-1:0] hit;
    for (genvar i = 0; i < GEN_PER_GRP; i++) begin : g_term
      assign hit[i] = pt_i[G*GEN_PER_GRP + i] & msk_i[(G*GEN_PER_GRP + i)*GRP + K];
    end
    assign sum_o[m] = |hit;
  end
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pt_clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  input  pt_cfg_pkg::mc_mode_t mode_i,
  output logic q_o,
  output logic y_o
);
  logic mc_clk, clr_eff;

  assign mc_clk  = mode_i.use_ptclk ? pt_clk_i : clk_i;
  assign clr_eff = ~rst_ni | clr_i;

  always_ff @(posedge mc_clk or posedge clr_eff or posedge set_i) begin
    if (clr_eff)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end

  assign y_o = mode_i.registered ? q_o : d_i;
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block #(
  parameter int N_IN        = 36,
  parameter int N_MC        = 16,
  parameter int GRP         = 4,
  parameter int GEN_PER_GRP = 20,
  parameter int MAX_PT      = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_en_i,
  input  logic            cfg_d_i,
  input  logic [N_IN-1:0] in_i,
  output logic [N_MC-1:0] mc_o,
  output logic            cfg_done_o,
  output logic            cfg_err_o
);
  import pt_cfg_pkg::*;

  localparam int N_GRP = N_MC / GRP;
  localparam int N_GEN = N_GRP * GEN_PER_GRP;
  localparam int N_PT  = N_GEN + N_SPECIAL;
  localparam int FW    = 2 * N_IN;
  localparam int AND_W = N_PT * FW;
  localparam int MSK_W = N_GEN * GRP;
  localparam int MOD_W = MODE_W * N_MC;
  localparam int CFG_W = AND_W + MSK_W + MOD_W;

  logic [CFG_W-1:0] shadow, act_cfg;
  logic             shadow_ok, cfg_en_q;
  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  sum, mc_q, mc_y;
  logic             pt_set, pt_clr, pt_clk;

  pt_cfg_store #(.CFG_W(CFG_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_en_i    (cfg_en_i),
    .cfg_d_i     (cfg_d_i),
    .shadow_ok_i (shadow_ok),
    .shadow_o    (shadow),
    .act_o       (act_cfg),
    .en_q_o      (cfg_en_q),
    .done_o      (cfg_done_o),
    .err_o       (cfg_err_o)
  );

  pt_cfg_check #(.N_MC(N_MC), .GRP(GRP), .GEN_PER_GRP(GEN_PER_GRP), .MAX_PT(MAX_PT)) u_check (
    .msk_i (shadow[AND_W +: MSK_W]),
    .ok_o  (shadow_ok)
  );

  pt_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i  (in_i),
    .sel_i (act_cfg[0 +: AND_W]),
    .pt_o  (pt)
  );

  assign pt_set = pt[N_GEN];
  assign pt_clr = pt[N_GEN+1];
  assign pt_clk = pt[N_GEN+2];

  pt_allocator #(.N_MC(N_MC), .GRP(GRP), .GEN_PER_GRP(GEN_PER_GRP)) u_alloc (
    .pt_i  (pt[N_GEN-1:0]),
    .msk_i (act_cfg[AND_W +: MSK_W]),
    .sum_o (sum)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    mc_mode_t mode;
    assign mode = act_cfg[AND_W + MSK_W + MODE_W*m +: MODE_W];
    pt_macrocell u_mc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pt_clk_i (pt_clk),
      .set_i    (pt_set),
      .clr_i    (pt_clr),
      .d_i      (sum[m]),
      .mode_i   (mode),
      .q_o      (mc_q[m]),
      .y_o      (mc_y[m])
    );
  end

  assign mc_o = (cfg_done_o && !cfg_en_i) ? mc_y : '0;
endmodule

// File: rtl/pt_logic_block_chk.sv
module pt_logic_block_chk #(
  parameter int N_MC  = 16,
  parameter int CFG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_en_q,
  input logic [CFG_W-1:0] act_cfg,
  input logic [N_MC-1:0]  mc_o,
  input logic [N_MC-1:0]  mc_q,
  input logic             pt_clr,
  input logic             cfg_done_o,
  input logic             cfg_err_o
);
  assert_outputs_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_done_o || cfg_en_i) |-> (mc_o == '0));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  assert_done_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> cfg_done_o);

  assert_refused_keeps_image_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $stable(act_cfg));

  assert_commit_on_enable_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_cfg) |-> ($past(cfg_en_q) && !$past(cfg_en_i)));

  assert_clear_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_clr |-> (mc_q == '0));
endmodule

bind pt_logic_block pt_logic_block_chk #(.N_MC(N_MC), .CFG_W(CFG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_en_i   (cfg_en_i),
  .cfg_en_q   (cfg_en_q),
  .act_cfg    (act_cfg),
  .mc_o       (mc_o),
  .mc_q       (mc_q),
  .pt_clr     (pt_clr),
  .cfg_done_o (cfg_done_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/tb_pt_logic_block.sv
`timescale 1ns/1ps
module tb_pt_logic_block;
  localparam int N_IN = 3, N_MC = 8, GRP = 4, GPG = 4, MAXP = 3;
  localparam int N_GEN = N_MC / GRP * GPG;
  localparam int N_PT  = N_GEN + 3;
  localparam int FW    = 2 * N_IN;
  localparam int AND_W = N_PT * FW;
  localparam int MSK_W = N_GEN * GRP;
  localparam int CFG_W = AND_W + MSK_W + 2 * N_MC;
  localparam int T_SET = N_GEN, T_CLR = N_GEN + 1, T_CLK = N_GEN + 2;

  logic clk = 0, rst_n = 0, cfg_en = 0, cfg_d = 0;
  logic [N_IN-1:0] in_v = '0;
  logic [N_MC-1:0] mc;
  logic done, err;

  int errors = 0, checks = 0;
  logic [CFG_W-1:0] cfg, act;
  logic [3:0] prev_pt;

  always #4 clk = ~clk;

  pt_logic_block #(.N_IN(N_IN), .N_MC(N_MC), .GRP(GRP), .GEN_PER_GRP(GPG), .MAX_PT(MAXP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_d_i(cfg_d),
    .in_i(in_v), .mc_o(mc), .cfg_done_o(done), .cfg_err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic lit(input int t, input int j);   cfg[t*FW + j] = 1'b1; endtask
  task automatic route(input int g, input int k); cfg[AND_W + g*GRP + k] = 1'b1; endtask
  task automatic mode(input int m, input bit r, input bit p);
    cfg[AND_W + MSK_W + 2*m]     = r;
    cfg[AND_W + MSK_W + 2*m + 1] = p;
  endtask

  function automatic bit term_val(input logic [CFG_W-1:0] c, input int t, input logic [N_IN-1:0] v);
    logic [FW-1:0] sel, field;
    sel   = c[t*FW +: FW];
    field = {~v, v};
    return (sel != '0) && ((field & sel) == sel);
  endfunction

  function automatic logic [N_MC-1:0] comb_val(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] v);
    logic [N_MC-1:0] r;
    r = '0;
    for (int m = 0; m < N_MC; m++)
      for (int i = 0; i < GPG; i++) begin
        int g;
        g = (m / GRP) * GPG + i;
        if (term_val(c, g, v) && c[AND_W + g*GRP + (m % GRP)]) r[m] = 1'b1;
      end
    return r;
  endfunction

  // R11: bit 0 first, one bit per edge, commit on the edge seeing enable low
  task automatic load(input bit ok);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = 0; i < CFG_W; i++) begin
      cfg_d = cfg[i];
      if (i == CFG_W / 2) chk("R7 outputs low while loading", 32'(mc), 32'h0);
      @(negedge clk);
    end
    cfg_en = 1'b0;
    @(negedge clk);
    if (ok) act = cfg;
  endtask

  task automatic sweep_comb(input string tag);
    for (int v = 0; v < 8; v++) begin
      in_v = 3'(v);
      #2;
      chk({tag, " R1 R3 R4 comb sweep"}, 32'(mc), 32'(comb_val(act, 3'(v))));
      chk("R2 empty term gives 0", 32'(mc[7]), 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cfg = '0; act = '0; prev_pt = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", 32'(mc), 32'h0);
    chk("R11 reset done", 32'(done), 32'h0);
    chk("R6 reset err", 32'(err), 32'h0);
    rst_n = 1'b1;
    in_v = 3'b101;
    @(negedge clk);
    chk("R7 unconfigured outputs low", 32'(mc), 32'h0);

    // image A: combinational, sharing and an empty term
    cfg = '0;
    lit(0, 0);
    lit(1, 1); lit(1, 5);
    lit(2, 3); lit(2, 4);
    lit(3, 2);
    lit(4, 0); lit(4, 1); lit(4, 2);
    lit(5, 0); lit(5, 3);
    lit(6, 4);
    for (int g = 0; g < N_GEN; g++) route(g, g % GRP);
    route(0, 1); route(0, 2); route(6, 0);
    load(1'b1);
    chk("R11 done after image", 32'(done), 32'h1);
    chk("R6 no error on valid image", 32'(err), 32'h0);
    sweep_comb("A");

    // image B: four terms on macrocell 0, over the limit
    in_v = 3'b001;
    @(negedge clk);
    chk("R3 precondition nonzero", 32'(mc[0]), 32'h1);
    route(1, 0); route(2, 0); route(3, 0);
    load(1'b0);
    chk("R5 R6 over-limit flags error", 32'(err), 32'h1);
    sweep_comb("R6 old image kept");

    // image C: registered, global and term clock, limit exactly met
    in_v = 3'b000;
    cfg = '0;
    lit(0, 0); lit(1, 1); lit(2, 3); lit(2, 4);
    lit(4, 0); lit(4, 1); lit(5, 3); lit(6, 4); lit(7, 1);
    lit(T_CLK, 2);
    route(0, 0); route(1, 0); route(2, 0);
    route(0, 1); route(2, 2); route(3, 3);
    route(4, 0); route(5, 1); route(7, 1); route(6, 2);
    route(4, 3); route(5, 3); route(6, 3);
    for (int m = 0; m < N_MC; m++) mode(m, 1'b1, m >= 4);
    load(1'b1);
    chk("R6 error stays sticky", 32'(err), 32'h1);
    in_v = 3'b100;
    #1;
    prev_pt = comb_val(act, 3'b000) >> 4;
    @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      logic [N_MC-1:0] e;
      in_v = {1'b0, 2'(v)};
      e = comb_val(act, in_v);
      @(negedge clk);
      chk("R5 R8 global registered", 32'(mc[3:0]), 32'(e[3:0]));
      chk("R9 term clock holds", 32'(mc[7:4]), 32'(prev_pt));
      in_v = {1'b1, 2'(v)};
      #1;
      chk("R9 term clock captures", 32'(mc[7:4]), 32'(e[7:4]));
      chk("R8 no capture without clk edge", 32'(mc[3:0]), 32'(e[3:0]));
      prev_pt = e[7:4];
      @(negedge clk);
    end

    // image D: preset and clear
    in_v = 3'b000;
    cfg = '0;
    lit(T_SET, 0);
    lit(T_CLR, 1);
    for (int m = 0; m < N_MC; m++) mode(m, 1'b1, 1'b0);
    load(1'b1);
    @(negedge clk);
    chk("R10 D=0 after edge", 32'(mc), 32'h0);
    in_v = 3'b001;
    #1;
    chk("R10 preset async", 32'(mc), 32'hff);
    @(negedge clk);
    chk("R10 preset held", 32'(mc), 32'hff);
    in_v = 3'b011;
    #1;
    chk("R10 clear wins", 32'(mc), 32'h0);
    in_v = 3'b010;
    #1;
    chk("R10 clear alone", 32'(mc), 32'h0);
    in_v = 3'b000;
    @(negedge clk);
    in_v = 3'b001;
    #1;
    in_v = 3'b000;
    #1;
    chk("R10 preset holds until edge", 32'(mc), 32'hff);
    @(negedge clk);
    chk("R8 edge loads D", 32'(mc), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule